// File: doc/BRIEF.md
# Mode-Switched Interrupt Priority Router

This block gathers level-sensitive interrupt requests from five sources and folds them into an eight-bit pending vector. The sources are peripheral controller A, peripheral controller B, the Ethernet controller, the serial controller and the non-maskable request. A live routing-mode input decides which pending position each source lands in. The highest set pending position `i` is presented to the processor as a three-bit priority level `i+1` and a vector number `i+25`. When nothing is pending, both outputs are zero.

In classic routing the Ethernet request stays out of the pending vector. Its level is forwarded to a single expansion-slot interrupt line instead. A built-in pulse generator raises the non-maskable request for a fixed number of clock cycles after a trigger. A trigger that arrives while a pulse is running restarts the count.

Top module: `irq_router`

## Requirements
- R1: With `route_classic`=1, request index 0 sets pending position 0 (level 1, vector 25), index 1 sets position 1 (level 2, vector 26), index 3 sets position 3 (level 4, vector 28) and index 4 sets position 6 (level 7, vector 31).
- R2: With `route_classic`=1, the Ethernet request (index 2) never enters the pending vector. `slot_irq` follows its level one clock edge later.
- R3: With `route_classic`=0, index 0 sets position 5 (level 6, vector 30), index 1 sets position 1, index 2 sets position 2 (level 3, vector 27), index 3 sets position 3 and index 4 sets position 6.
- R4: With `route_classic`=0, `slot_irq` is 0 whatever the Ethernet level is.
- R5: Requests are levels. Dropping a request clears its pending position, and no request is latched.
- R6: When several positions are pending, the highest one alone sets the level and the vector.
- R7: With nothing pending, `irq_level` and `irq_vector` are both 0.
- R8: Synchronous reset clears the pending vector, the outputs and `slot_irq`, and it cancels a running non-maskable pulse.
- R9: A one-cycle `nmi_trigger` holds the non-maskable request for exactly `NMI_HOLD` cycles, so level 7 is shown for exactly `NMI_HOLD` consecutive cycles.
- R10: A trigger during a running pulse reloads the count to `NMI_HOLD`. This includes a trigger on the pulse's final cycle, and the level-7 window then has no gap.
- R11: A change of `route_classic` rebuilds every pending position from the current request levels, so no position from the old mapping survives.
- R12: `slot_irq` changes one clock edge after its inputs change. `irq_level` and `irq_vector` change two clock edges after their inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| route_classic | input | 1 | Routing mode: 1 classic, 0 alternate |
| src_req | input | 5 | Request levels: 0 ctrl A, 1 ctrl B, 2 Ethernet, 3 serial, 4 non-maskable |
| nmi_trigger | input | 1 | Starts or restarts the timed non-maskable pulse |
| irq_level | output | 3 | Processor priority level (0 = none) |
| irq_vector | output | 8 | Vector number (0 = none) |
| slot_irq | output | 1 | Ethernet level forwarded to the expansion slot in classic mode |

## Verification
Two functions can act in the same cycle: the pulse timer's final cycle and a fresh trigger. The bench fires a second trigger exactly on the edge where the counter would reach zero. It then judges the result from the level-7 window seen at the ports: the window must be twice the hold length and must fall only once. A second collision pairs a mode flip with a steady Ethernet level. Pending and passthrough must both swap over within the stated latency.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NUM_SRC  = 5;
    localparam int PEND_W   = 8;
    localparam int LVL_W    = 3;
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 25;

    localparam int IDX_CTLA = 0;
    localparam int IDX_CTLB = 1;
    localparam int IDX_ENET = 2;
    localparam int IDX_SER  = 3;
    localparam int IDX_NMI  = 4;

    typedef enum logic {
        MODE_ALT     = 1'b0,
        MODE_CLASSIC = 1'b1
    } route_mode_e;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
    } irq_out_t;

    // Pending position a source occupies under a routing mode.
    function automatic logic [2:0] pend_pos(input int src, input route_mode_e m);
        case (src)
            IDX_CTLA: return (m == MODE_CLASSIC) ? 3'd0 : 3'd5;
            IDX_CTLB: return 3'd1;
            IDX_ENET: return 3'd2;
            IDX_SER:  return 3'd3;
            default:  return 3'd6;
        endcase
    endfunction

    // Source that bypasses the pending vector under a routing mode.
    function automatic logic diverted(input int src, input route_mode_e m);
        return (m == MODE_CLASSIC) && (src == IDX_ENET);
    endfunction

    // Highest set position wins; empty vector yields zeros.
    function automatic irq_out_t encode(input logic [PEND_W-1:0] p);
        irq_out_t r;
        r = '0;
        for (int i = 0; i < PEND_W; i++) begin
            if (p[i]) begin
                r.lvl = LVL_W'(i + 1);
                r.vec = VEC_W'(i + VEC_BASE);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               classic,
    input  logic [NUM_SRC-1:0] lvl,
    output logic [PEND_W-1:0]  pend_q,
    output logic               slot_q
);

    route_mode_e        mode_sel;
    logic [PEND_W-1:0]  pend_nxt;
    logic               slot_nxt;

    assign mode_sel = route_mode_e'(classic);

    always_comb begin
        pend_nxt = '0;
        slot_nxt = (mode_sel == MODE_CLASSIC) & lvl[IDX_ENET];
        for (int s = 0; s < NUM_SRC; s++) begin
            if (!diverted(s, mode_sel)) begin
                pend_nxt[pend_pos(s, mode_sel)] = pend_nxt[pend_pos(s, mode_sel)] | lvl[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            slot_q <= 1'b0;
        end else begin
            pend_q <= pend_nxt;
            slot_q <= slot_nxt;
        end
    end

    // R2: in classic mode the Ethernet level stays out of the pending vector
    a_r2_enet_diverted: assert property (@(posedge clk) disable iff (rst)
        classic |=> !pend_q[2]);

    // R4: passthrough is quiet in alternate mode
    a_r4_slot_quiet: assert property (@(posedge clk) disable iff (rst)
        !classic |=> !slot_q);

    // R11: ctrl A position follows the mode that was live at capture
    a_r11_ctla_rebuilt: assert property (@(posedge clk) disable iff (rst)
        (classic && !lvl[0]) |=> !pend_q[0] && !pend_q[5]);

    // R5: a dropped serial request leaves no pending bit
    a_r5_level_drop: assert property (@(posedge clk) disable iff (rst)
        !lvl[3] |=> !pend_q[3]);

endmodule

// File: rtl/irq_nmi_pulse.sv
module irq_nmi_pulse #(
    parameter int HOLD = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);

    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= CW'(HOLD);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);

    // R10: every trigger reloads the full count, even mid-pulse
    a_r10_reload: assert property (@(posedge clk) disable iff (rst)
        trig |=> cnt_q == CW'(HOLD));

    // R9: the count never exceeds the hold length
    a_r9_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(HOLD));

    // R8: reset cancels a running pulse
    a_r8_cancel: assert property (@(posedge clk)
        rst |=> !active);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PEND_W-1:0] pend,
    output logic [LVL_W-1:0]  lvl_q,
    output logic [VEC_W-1:0]  vec_q
);

    irq_out_t enc;

    assign enc = encode(pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            vec_q <= '0;
        end else begin
            lvl_q <= enc.lvl;
            vec_q <= enc.vec;
        end
    end

    // R7: empty pending vector yields zero outputs next cycle
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |=> (lvl_q == '0) && (vec_q == '0));

    // R6: the top populated position dominates all lower ones
    a_r6_top_wins: assert property (@(posedge clk) disable iff (rst)
        pend[6] |=> (lvl_q == LVL_W'(7)) && (vec_q == VEC_W'(VEC_BASE + 6)));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
#(
    parameter int NMI_HOLD = 100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               route_classic,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               nmi_trigger,
    output logic [LVL_W-1:0]   irq_level,
    output logic [VEC_W-1:0]   irq_vector,
    output logic               slot_irq
);

    logic               nmi_active;
    logic [NUM_SRC-1:0] eff_req;
    logic [PEND_W-1:0]  pend;

    irq_nmi_pulse #(.HOLD(NMI_HOLD)) u_nmi (
        .clk    (clk),
        .rst    (rst),
        .trig   (nmi_trigger),
        .active (nmi_active)
    );

    always_comb begin
        eff_req          = src_req;
        eff_req[IDX_NMI] = src_req[IDX_NMI] | nmi_active;
    end

    irq_src_map u_map (
        .clk     (clk),
        .rst     (rst),
        .classic (route_classic),
        .lvl     (eff_req),
        .pend_q  (pend),
        .slot_q  (slot_irq)
    );

    irq_prio_enc u_enc (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend),
        .lvl_q (irq_level),
        .vec_q (irq_vector)
    );

    // R12: a pulse start reaches the level output two edges later
    a_r12_nmi_latency: assert property (@(posedge clk) disable iff (rst)
        nmi_active |=> ##1 (irq_level == LVL_W'(7)));

endmodule

// File: tb/irq_router_test.sv
module irq_router_test;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       route_classic = 1'b0;
    logic [4:0] src_req = '0;
    logic       nmi_trigger = 1'b0;
    logic [2:0] irq_level;
    logic [7:0] irq_vector;
    logic       slot_irq;

    int vectors = 0;
    int miscompares = 0;

    irq_router #(.NMI_HOLD(HOLD)) uut (
        .clk           (clk),
        .rst           (rst),
        .route_classic (route_classic),
        .src_req       (src_req),
        .nmi_trigger   (nmi_trigger),
        .irq_level     (irq_level),
        .irq_vector    (irq_vector),
        .slot_irq      (slot_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input int lvl, input int vec);
        chk({tag, " level"}, int'(irq_level), lvl);
        chk({tag, " vector"}, int'(irq_vector), vec);
    endtask

    task automatic t_reset_state();
        // R8 / R7: after reset nothing is pending
        chk_out("R8 reset", 0, 0);
        chk("R8 reset slot", int'(slot_irq), 0);
    endtask

    task automatic t_classic_map();
        route_classic = 1'b1;
        src_req = 5'b00001; step(2); chk_out("R1 ctlA", 1, 25);
        src_req = 5'b00010; step(2); chk_out("R1 ctlB", 2, 26);
        src_req = 5'b01000; step(2); chk_out("R1 serial", 4, 28);
        src_req = 5'b10000; step(2); chk_out("R1 nmi", 7, 31);
        // R2: Ethernet only on the slot line, one edge later (R12)
        src_req = 5'b00100; step(1);
        chk("R12 slot after one edge", int'(slot_irq), 1);
        step(1);
        chk_out("R2 enet not pending", 0, 0);
        src_req = 5'b00000; step(1);
        chk("R2 slot follows drop", int'(slot_irq), 0);
        step(1);
    endtask

    task automatic t_alt_map();
        route_classic = 1'b0;
        src_req = 5'b00001; step(2); chk_out("R3 ctlA", 6, 30);
        src_req = 5'b00100; step(2); chk_out("R3 enet", 3, 27);
        chk("R4 slot quiet", int'(slot_irq), 0);
        src_req = 5'b01000; step(2); chk_out("R3 serial", 4, 28);
        src_req = 5'b00010; step(2); chk_out("R3 ctlB", 2, 26);
        src_req = 5'b10000; step(2); chk_out("R3 nmi", 7, 31);
        src_req = 5'b00000; step(2);
    endtask

    task automatic t_priority_release();
        route_classic = 1'b0;
        src_req = 5'b01111; step(2); chk_out("R6 highest ctlA", 6, 30);
        src_req = 5'b01110; step(2); chk_out("R6 serial over enet", 4, 28);
        src_req = 5'b00110; step(1);
        chk_out("R12 not yet after one edge", 4, 28);
        step(1); chk_out("R5 release serial", 3, 27);
        src_req = 5'b00000; step(2); chk_out("R7 empty", 0, 0);
    endtask

    task automatic t_mode_switch();
        route_classic = 1'b1;
        src_req = 5'b00101; step(2);
        chk_out("R11 classic start", 1, 25);
        chk("R11 classic slot", int'(slot_irq), 1);
        route_classic = 1'b0; step(2);
        chk_out("R11 rebuilt alt", 6, 30);
        chk("R4 slot after flip", int'(slot_irq), 0);
        src_req = 5'b00100; step(2);
        chk_out("R11 no stale ctlA", 3, 27);
        route_classic = 1'b1; step(2);
        chk_out("R11 enet leaves pending", 0, 0);
        chk("R2 slot after flip", int'(slot_irq), 1);
        src_req = 5'b00000; route_classic = 1'b0; step(2);
    endtask

    task automatic t_nmi_pulse();
        int seen = 0;
        nmi_trigger = 1'b1; step(1); nmi_trigger = 1'b0;
        for (int i = 0; i < 3 * HOLD; i++) begin
            step(1);
            if (irq_level == 3'd7) seen++;
        end
        chk("R9 pulse length", seen, HOLD);
        chk_out("R9 after pulse", 0, 0);
    endtask

    task automatic t_retrigger_mid();
        int seen = 0;
        nmi_trigger = 1'b1; step(1); nmi_trigger = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            step(1);
            if (irq_level == 3'd7) seen++;
        end
        nmi_trigger = 1'b1; step(1); nmi_trigger = 1'b0;
        if (irq_level == 3'd7) seen++;
        for (int i = 0; i < 3 * HOLD; i++) begin
            step(1);
            if (irq_level == 3'd7) seen++;
        end
        chk("R10 mid restart length", seen, 5 + HOLD);
    endtask

    task automatic t_retrigger_last();
        int seen = 0;
        int falls = 0;
        logic prev = 1'b0;
        nmi_trigger = 1'b1; step(1); nmi_trigger = 1'b0;
        for (int i = 1; i <= 4 * HOLD; i++) begin
            // trigger lands on the edge where the count would expire
            if (i == HOLD) nmi_trigger = 1'b1;
            step(1);
            nmi_trigger = 1'b0;
            if (irq_level == 3'd7) seen++;
            if (prev && irq_level != 3'd7) falls++;
            prev = (irq_level == 3'd7);
        end
        chk("R10 last-cycle restart length", seen, 2 * HOLD);
        chk("R10 no gap", falls, 1);
    endtask

    task automatic t_reset_cancel();
        bit stuck = 1'b0;
        route_classic = 1'b1;
        src_req = 5'b00100;
        nmi_trigger = 1'b1; step(1); nmi_trigger = 1'b0;
        step(2);
        chk("R8 pulse running", int'(irq_level), 7);
        rst = 1'b1; step(1); rst = 1'b0;
        src_req = 5'b00000;
        chk_out("R8 outputs cleared", 0, 0);
        chk("R8 slot cleared", int'(slot_irq), 0);
        for (int i = 0; i < HOLD + 3; i++) begin
            step(1);
            if (irq_level != 3'd0) stuck = 1'b1;
        end
        chk("R8 pulse cancelled", int'(stuck), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        t_reset_state();
        t_classic_map();
        t_alt_map();
        t_priority_release();
        t_mode_switch();
        t_nmi_pulse();
        t_retrigger_mid();
        t_retrigger_last();
        t_reset_cancel();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule